// File: doc/BRIEF.md
# Descriptor Ring Master Controller

This block is the register-side control front end of a descriptor-driven SMBus host. Software keeps a ring of fixed-size descriptors in memory. It tells the controller where the ring starts, how many slots it has and how far the ring has been filled. It fills the ring by moving a firmware head pointer in a control register. The controller follows that head with its own hardware tail pointer. For each slot between tail and head it asks a fetch engine for the descriptor at `base + tail * DESC_BYTES`. It then waits for the downstream bus sequencer to report that the descriptor has finished. After that it steps the tail, wrapping after the last slot.

Each completion carries two flags: whether the descriptor asked for an interrupt, and whether it ended in error. These set sticky flags in the status register. Software clears them by writing a one to each flag. A level interrupt output combines the completion flag with the error flag, and the error flag passes through only when error interrupts are enabled. The start bit gates new work. Clearing it stops further fetches but lets the descriptor already in flight finish.

Top module: `dring_master`

## Requirements
- R1: After reset, every register reads zero, `irq` is 0 and `fetch_req` is 0.
- R2: A fetch request is raised only when the start bit (control bit 0) is 1 and the tail differs from the head (control bits 23:16). The request presents `fetch_idx` equal to the tail and `fetch_addr` equal to base + tail*16.
- R3: `fetch_req` stays high with a stable index until `fetch_ack` is seen. No new request appears while a descriptor is awaiting completion.
- R4: Each `done_valid` received while a descriptor awaits completion advances the tail (status bits 23:16) by one. The tail wraps to 0 after the slot numbered by the ring-size register (entries minus one, low 8 bits). A `done_valid` at any other time is ignored.
- R5: The busy flag (status bit 0) is 1 from the cycle the fetch request is raised until the completion is taken.
- R6: A completion with `done_irq` set sets the completion flag (status bit 5). A completion with `done_err` set sets the error flag (status bit 4).
- R7: Writing 1 to status bit 5 or bit 4 clears that flag, and writing 0 leaves it unchanged. If a completion sets a flag in the same cycle that a write clears it, the flag ends up set.
- R8: `irq` equals the completion flag OR (the error flag AND the error-interrupt enable, control bit 4).
- R9: After the start bit is cleared, the descriptor in flight still completes and the tail advances, but no further fetch is requested.
- R10: Register offsets are: base at 0x00, written as one 64-bit value; control at 0x08; status at 0x0C; ring size at 0x10. Each reads back what was written in its defined fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | RA_W | Register write offset |
| reg_wr_data | input | 64 | Register write data |
| reg_rd_addr | input | RA_W | Register read offset |
| reg_rd_data | output | 64 | Register read data (combinational) |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_ack | input | 1 | Fetch accepted |
| fetch_addr | output | ADDR_W | Address of the descriptor to fetch |
| fetch_idx | output | PTR_W | Ring slot being fetched |
| done_valid | input | 1 | Sequencer reports descriptor finished |
| done_irq | input | 1 | Finished descriptor requested an interrupt |
| done_err | input | 1 | Finished descriptor ended in error |
| irq | output | 1 | Level interrupt |

## Verification
Directed cases cover four situations: head equal to tail with start set, which tells a correct gate apart from one that fetches whenever start is set; a run across the last slot, which separates wrap-at-size from wrap-at-pointer-width; a start bit cleared mid-flight; and a write-one-clear that coincides with a completion setting the same flag. Constrained-random rounds pick a ring size, a head distance, ack-to-completion delays and the interrupt/error flags of each completion. They compare tail, flags, fetch address and `irq` against a bench model. The varied gap between ack and completion exposes any request raised while one descriptor is still outstanding.

// File: rtl/dring_pkg.sv
package dring_pkg;
   typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_WAIT} sq_state_e;

   localparam int OFS_BASE  = 'h00;
   localparam int OFS_CTRL  = 'h08;
   localparam int OFS_STAT  = 'h0C;
   localparam int OFS_SIZE  = 'h10;

   localparam int BIT_START = 0;
   localparam int BIT_MEIE  = 4;
   localparam int BIT_BUSY  = 0;
   localparam int BIT_MEIS  = 4;
   localparam int BIT_MIS   = 5;
   localparam int PTR_LSB   = 16;
endpackage

// File: rtl/dring_wrap.sv
module dring_wrap #(
   parameter int PTR_W = 8
) (
   input  logic [PTR_W-1:0] cur,
   input  logic [PTR_W-1:0] last,
   output logic [PTR_W-1:0] nxt
);
   always_comb begin
      if (cur == last) nxt = '0;
      else             nxt = cur + 1'b1;
   end
endmodule

// File: rtl/dring_seq.sv
module dring_seq
   import dring_pkg::*;
#(
   parameter int PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PTR_W-1:0] head,
   input  logic [PTR_W-1:0] last,
   input  logic             ack,
   input  logic             done_valid,
   output logic             fetch_req,
   output logic [PTR_W-1:0] tail,
   output logic             busy,
   output logic             cmpl
);
   sq_state_e        st;
   logic [PTR_W-1:0] tail_nxt;

   dring_wrap #(.PTR_W(PTR_W)) u_wrap (
      .cur  (tail),
      .last (last),
      .nxt  (tail_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SQ_IDLE;
         tail <= '0;
      end else begin
         case (st)
            SQ_IDLE:  if (start && (tail != head)) st <= SQ_FETCH;
            SQ_FETCH: if (ack) st <= SQ_WAIT;
            SQ_WAIT:  if (done_valid) begin
                         st   <= SQ_IDLE;
                         tail <= tail_nxt;
                      end
            default:  st <= SQ_IDLE;
         endcase
      end
   end

   assign fetch_req = (st == SQ_FETCH);
   assign busy      = (st != SQ_IDLE);
   assign cmpl      = (st == SQ_WAIT) && done_valid;
endmodule

// File: rtl/dring_regs.sv
module dring_regs
   import dring_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int PTR_W  = 8,
   parameter int RA_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [RA_W-1:0]   wr_addr,
   input  logic [63:0]       wr_data,
   input  logic [RA_W-1:0]   rd_addr,
   output logic [63:0]       rd_data,
   input  logic [PTR_W-1:0]  tail,
   input  logic              busy,
   input  logic              cmpl,
   input  logic              cmpl_irq,
   input  logic              cmpl_err,
   output logic [ADDR_W-1:0] base,
   output logic [PTR_W-1:0]  head,
   output logic [PTR_W-1:0]  last,
   output logic              start,
   output logic              meie,
   output logic              mis,
   output logic              meis
);
   logic wr_base, wr_ctrl, wr_stat, wr_size;

   assign wr_base = wr_en && (wr_addr == RA_W'(OFS_BASE));
   assign wr_ctrl = wr_en && (wr_addr == RA_W'(OFS_CTRL));
   assign wr_stat = wr_en && (wr_addr == RA_W'(OFS_STAT));
   assign wr_size = wr_en && (wr_addr == RA_W'(OFS_SIZE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base  <= '0;
         head  <= '0;
         last  <= '0;
         start <= 1'b0;
         meie  <= 1'b0;
      end else begin
         if (wr_base) base <= wr_data[ADDR_W-1:0];
         if (wr_size) last <= wr_data[PTR_W-1:0];
         if (wr_ctrl) begin
            head  <= wr_data[PTR_LSB +: PTR_W];
            start <= wr_data[BIT_START];
            meie  <= wr_data[BIT_MEIE];
         end
      end
   end

   // sticky flags: a completion wins over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mis  <= 1'b0;
         meis <= 1'b0;
      end else begin
         if (cmpl && cmpl_irq)                 mis <= 1'b1;
         else if (wr_stat && wr_data[BIT_MIS]) mis <= 1'b0;
         if (cmpl && cmpl_err)                  meis <= 1'b1;
         else if (wr_stat && wr_data[BIT_MEIS]) meis <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         RA_W'(OFS_BASE): rd_data[ADDR_W-1:0] = base;
         RA_W'(OFS_CTRL): begin
            rd_data[PTR_LSB +: PTR_W] = head;
            rd_data[BIT_MEIE]         = meie;
            rd_data[BIT_START]        = start;
         end
         RA_W'(OFS_STAT): begin
            rd_data[PTR_LSB +: PTR_W] = tail;
            rd_data[BIT_MIS]          = mis;
            rd_data[BIT_MEIS]         = meis;
            rd_data[BIT_BUSY]         = busy;
         end
         RA_W'(OFS_SIZE): rd_data[PTR_W-1:0] = last;
         default:         rd_data = '0;
      endcase
   end
endmodule

// File: rtl/dring_master.sv
module dring_master
   import dring_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int PTR_W      = 8,
   parameter int DESC_BYTES = 16,
   parameter int RA_W       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [RA_W-1:0]   reg_wr_addr,
   input  logic [63:0]       reg_wr_data,
   input  logic [RA_W-1:0]   reg_rd_addr,
   output logic [63:0]       reg_rd_data,
   output logic              fetch_req,
   input  logic              fetch_ack,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic [PTR_W-1:0]  fetch_idx,
   input  logic              done_valid,
   input  logic              done_irq,
   input  logic              done_err,
   output logic              irq
);
   localparam bit DESC_POW2 = (DESC_BYTES > 0) && ((DESC_BYTES & (DESC_BYTES - 1)) == 0);
   localparam int DESC_SH   = $clog2(DESC_BYTES);

   if (PTR_W < 1 || PTR_W > 8) begin : g_bad_ptr
      $error("PTR_W must lie in 1..8");
   end
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr
      $error("ADDR_W must lie in 8..64");
   end
   if (RA_W < 5) begin : g_bad_ra
      $error("RA_W must cover offset 0x10");
   end
   if (DESC_BYTES < 1) begin : g_bad_desc
      $error("DESC_BYTES must be positive");
   end

   logic [ADDR_W-1:0] rg_base;
   logic [PTR_W-1:0]  rg_head, rg_last, sq_tail;
   logic              rg_start, rg_meie, rg_mis, rg_meis;
   logic              sq_busy, sq_cmpl;

   dring_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .RA_W(RA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en),
      .wr_addr  (reg_wr_addr),
      .wr_data  (reg_wr_data),
      .rd_addr  (reg_rd_addr),
      .rd_data  (reg_rd_data),
      .tail     (sq_tail),
      .busy     (sq_busy),
      .cmpl     (sq_cmpl),
      .cmpl_irq (done_irq),
      .cmpl_err (done_err),
      .base     (rg_base),
      .head     (rg_head),
      .last     (rg_last),
      .start    (rg_start),
      .meie     (rg_meie),
      .mis      (rg_mis),
      .meis     (rg_meis)
   );

   dring_seq #(.PTR_W(PTR_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (rg_start),
      .head       (rg_head),
      .last       (rg_last),
      .ack        (fetch_ack),
      .done_valid (done_valid),
      .fetch_req  (fetch_req),
      .tail       (sq_tail),
      .busy       (sq_busy),
      .cmpl       (sq_cmpl)
   );

   if (DESC_POW2) begin : g_addr_shift
      assign fetch_addr = rg_base + (ADDR_W'(sq_tail) << DESC_SH);
   end else begin : g_addr_mul
      assign fetch_addr = rg_base + ADDR_W'(sq_tail) * ADDR_W'(DESC_BYTES);
   end

   assign fetch_idx = sq_tail;
   assign irq       = rg_mis | (rg_meis & rg_meie);
endmodule

// File: rtl/dring_master_chk.sv
module dring_master_chk #(
   parameter int PTR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fetch_req,
   input logic             fetch_ack,
   input logic [PTR_W-1:0] fetch_idx,
   input logic             done_irq,
   input logic             busy,
   input logic             cmpl,
   input logic             start,
   input logic [PTR_W-1:0] head,
   input logic [PTR_W-1:0] tail,
   input logic             mis
);
   // R3
   fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_idx));

   // R2
   fetch_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_req) |-> $past(start && (tail != head)));

   // R5
   busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> busy);

   // R4
   tail_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tail) |-> $past(cmpl));

   // R6
   mis_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mis) |-> $past(cmpl && done_irq));

   // R9
   stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start && !busy |=> !fetch_req);
endmodule

bind dring_master dring_master_chk #(.PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fetch_req (fetch_req),
   .fetch_ack (fetch_ack),
   .fetch_idx (fetch_idx),
   .done_irq  (done_irq),
   .busy      (sq_busy),
   .cmpl      (sq_cmpl),
   .start     (rg_start),
   .head      (rg_head),
   .tail      (sq_tail),
   .mis       (rg_mis)
);

// File: tb/dring_master_bench.sv
`timescale 1ns/1ps
module dring_master_bench;
   localparam int RA_W = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_wr_en = 1'b0;
   logic [RA_W-1:0] reg_wr_addr = '0;
   logic [63:0]     reg_wr_data = '0;
   logic [RA_W-1:0] reg_rd_addr = '0;
   logic [63:0]     reg_rd_data;
   logic            fetch_req, fetch_ack = 1'b0;
   logic [63:0]     fetch_addr;
   logic [7:0]      fetch_idx;
   logic            done_valid = 1'b0, done_irq = 1'b0, done_err = 1'b0;
   logic            irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 1'b0;

   logic [63:0] e_base;
   logic [7:0]  e_tail, e_head, e_last;
   bit          e_mis, e_meis, e_meie, e_start;

   always #2.5 clk = ~clk;

   dring_master u_dring_master (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .fetch_req(fetch_req), .fetch_ack(fetch_ack),
      .fetch_addr(fetch_addr), .fetch_idx(fetch_idx),
      .done_valid(done_valid), .done_irq(done_irq), .done_err(done_err),
      .irq(irq)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000 && !finished) begin
         errors = errors + 1;
         $display("FAIL watchdog act=%0d exp=<100000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [7:0] nxt(input logic [7:0] p);
      return (p == e_last) ? 8'd0 : p + 8'd1;
   endfunction

   function automatic logic [63:0] stat_exp(input bit busy);
      return (64'(e_tail) << 16) | (64'(e_mis) << 5) | (64'(e_meis) << 4) | 64'(busy);
   endfunction

   function automatic logic [63:0] ctrl_word(input logic [7:0] h, input bit ie, input bit st);
      return (64'(h) << 16) | (64'(ie) << 4) | 64'(st);
   endfunction

   function automatic bit irq_exp();
      return e_mis | (e_meis & e_meie);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [RA_W-1:0] a, output logic [63:0] d);
      reg_rd_addr = a;
      #0.5;
      d = reg_rd_data;
   endtask

   task automatic wr(input logic [RA_W-1:0] a, input logic [63:0] d);
      reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
      @(posedge clk); @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic set_ctrl(input logic [7:0] h, input bit ie, input bit st);
      e_head = h; e_meie = ie; e_start = st;
      wr(5'h08, ctrl_word(h, ie, st));
   endtask

   task automatic wait_req();
      for (int i = 0; i < 20 && !fetch_req; i++) @(negedge clk);
   endtask

   task automatic serve(input bit ir, input bit er, input int dly);
      logic [63:0] d;
      wait_req();
      chk(fetch_req == 1'b1, "R2 request raised", 64'(fetch_req), 64'd1);
      chk(fetch_idx == e_tail, "R2 fetch index", 64'(fetch_idx), 64'(e_tail));
      chk(fetch_addr == e_base + 64'(e_tail) * 64'd16, "R2 fetch address",
          fetch_addr, e_base + 64'(e_tail) * 64'd16);
      rd(5'h0C, d);
      chk(d[0] == 1'b1, "R5 busy during request", 64'(d[0]), 64'd1);
      fetch_ack = 1'b1;
      @(posedge clk); @(negedge clk);
      fetch_ack = 1'b0;
      for (int i = 0; i < dly; i++) begin
         chk(fetch_req == 1'b0, "R3 no request while waiting", 64'(fetch_req), 64'd0);
         @(negedge clk);
      end
      rd(5'h0C, d);
      chk(d == stat_exp(1'b1), "R5 busy until completion", d, stat_exp(1'b1));
      done_valid = 1'b1; done_irq = ir; done_err = er;
      @(posedge clk); @(negedge clk);
      done_valid = 1'b0; done_irq = 1'b0; done_err = 1'b0;
      e_tail = nxt(e_tail);
      if (ir) e_mis = 1'b1;
      if (er) e_meis = 1'b1;
      rd(5'h0C, d);
      chk(d == stat_exp(1'b0), "R4 R6 status after completion", d, stat_exp(1'b0));
      chk(irq == irq_exp(), "R8 irq level", 64'(irq), 64'(irq_exp()));
   endtask

   task automatic idle_check(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(fetch_req == 1'b0, req, 64'(fetch_req), 64'd0);
      end
   endtask

   initial begin
      logic [63:0] d;
      void'($urandom(32'd4242));
      e_base = '0; e_tail = '0; e_head = '0; e_last = '0;
      e_mis = 0; e_meis = 0; e_meie = 0; e_start = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(5'h00, d); chk(d == 0, "R1 base reset", d, 0);
      rd(5'h08, d); chk(d == 0, "R1 ctrl reset", d, 0);
      rd(5'h0C, d); chk(d == 0, "R1 status reset", d, 0);
      rd(5'h10, d); chk(d == 0, "R1 size reset", d, 0);
      chk(irq == 0 && fetch_req == 0, "R1 outputs reset", 64'({irq, fetch_req}), 0);

      // R10 register layout
      e_base = 64'h1234_5678_9ABC_DE00;
      wr(5'h00, e_base);
      rd(5'h00, d); chk(d == e_base, "R10 base 64-bit", d, e_base);
      e_last = 8'd3;
      wr(5'h10, 64'hFFFF_FF03);
      rd(5'h10, d); chk(d == 64'h3, "R10 size low byte", d, 64'h3);

      // R2 start with head == tail: nothing fetched
      set_ctrl(8'd0, 1'b0, 1'b1);
      rd(5'h08, d); chk(d == ctrl_word(0, 0, 1), "R10 ctrl readback", d, ctrl_word(0, 0, 1));
      idle_check(5, "R2 no fetch when head equals tail");

      // R2 head moved but start clear: nothing fetched
      set_ctrl(8'd2, 1'b0, 1'b0);
      idle_check(5, "R2 no fetch when start clear");

      // R6 R8 two descriptors, one interrupting, one erroring
      set_ctrl(8'd2, 1'b0, 1'b1);
      serve(1'b1, 1'b0, 2);
      serve(1'b0, 1'b1, 0);
      idle_check(4, "R2 drained ring stays idle");

      // R7 write zero does nothing, write one clears
      wr(5'h0C, 64'h0);
      rd(5'h0C, d); chk(d == stat_exp(0), "R7 zero write no effect", d, stat_exp(0));
      wr(5'h0C, 64'h20); e_mis = 0;
      rd(5'h0C, d); chk(d == stat_exp(0), "R7 clear completion flag", d, stat_exp(0));
      chk(irq == 1'b0, "R8 error masked", 64'(irq), 0);
      set_ctrl(8'd2, 1'b1, 1'b1);
      chk(irq == 1'b1, "R8 error enabled", 64'(irq), 1);
      wr(5'h0C, 64'h10); e_meis = 0;
      chk(irq == 1'b0, "R8 error cleared", 64'(irq), 0);

      // R4 wrap across the last slot (tail 2 -> 3 -> 0 -> 1)
      set_ctrl(8'd1, 1'b1, 1'b1);
      serve(1'b0, 1'b0, 1);
      serve(1'b0, 1'b0, 1);
      chk(e_tail == 8'd0, "R4 wrapped to zero", 64'(e_tail), 0);
      serve(1'b0, 1'b0, 0);

      // R4 stray completion while idle is ignored
      done_valid = 1'b1; done_irq = 1'b1;
      @(posedge clk); @(negedge clk);
      done_valid = 1'b0; done_irq = 1'b0;
      rd(5'h0C, d); chk(d == stat_exp(0), "R4 stray completion ignored", d, stat_exp(0));

      // R9 clear start mid-flight
      set_ctrl(8'd0, 1'b1, 1'b1);
      wait_req();
      fetch_ack = 1'b1;
      @(posedge clk); @(negedge clk);
      fetch_ack = 1'b0;
      set_ctrl(8'd0, 1'b1, 1'b0);
      // R7 set wins over same-cycle clear
      done_valid = 1'b1; done_irq = 1'b1;
      reg_wr_en = 1'b1; reg_wr_addr = 5'h0C; reg_wr_data = 64'h20;
      @(posedge clk); @(negedge clk);
      done_valid = 1'b0; done_irq = 1'b0; reg_wr_en = 1'b0;
      e_tail = nxt(e_tail); e_mis = 1;
      rd(5'h0C, d); chk(d == stat_exp(0), "R7 R9 set wins, in-flight finished", d, stat_exp(0));
      idle_check(6, "R9 no fetch after stop");
      set_ctrl(8'd0, 1'b1, 1'b1);
      while (e_tail != e_head) serve(1'b0, 1'b0, 0);
      wr(5'h0C, 64'h30); e_mis = 0; e_meis = 0;

      // random rounds
      for (int r = 0; r < 24; r++) begin
         int k;
         logic [7:0] h;
         e_last = e_tail + 8'($urandom % 6);
         wr(5'h10, 64'(e_last));
         if (e_last == 0) continue;
         k = 1 + int'($urandom % e_last);
         h = e_tail;
         for (int i = 0; i < k; i++) h = nxt(h);
         set_ctrl(h, 1'($urandom % 2), 1'b1);
         for (int i = 0; i < k; i++)
            serve(1'($urandom % 3 == 0), 1'($urandom % 4 == 0), int'($urandom % 4));
         idle_check(2, "R2 random ring drained");
         wr(5'h0C, 64'h30); e_mis = 0; e_meis = 0;
         chk(irq == 1'b0, "R7 random clear", 64'(irq), 0);
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule